// File: doc/BRIEF.md
# Not-Recently-Used Page Frame Victim Selector

This block keeps a small amount of usage history for every resident page frame and, when the memory manager has to free a frame after a page fault, names the frame to evict. Each frame carries a referenced flag and a modified flag. A reference strobe reports every access to a frame. A periodic tick ages the history by clearing all referenced flags. A refill strobe marks a frame that has just been loaded with a fresh page.

On a victim request the block ranks the frames into four classes from their two flags, with cold and clean frames first and hot and dirty frames last. It then picks one member of the cheapest class that has any members. A free-running choice inside that class comes from a 16-bit linear feedback shift register. The register sets a starting frame, and the scan wraps around from that frame to find the first class member. Along with the frame index the block reports whether the victim is dirty, so that the caller knows to save it before reusing the frame.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every referenced and modified flag is clear and `vic_vld` is low. The first victim request after reset therefore returns frame 1 (the low bits of the seed 0xACE1) with `vic_dirty` low.
- R2: A cycle with `acc_vld` high sets the referenced flag of frame `acc_idx`. If `acc_wr` is also high, the modified flag of that frame is set as well.
- R3: The class of a frame is the two-bit value {referenced, modified}: 0 cold/clean, 1 cold/dirty, 2 hot/clean, 3 hot/dirty. The victim always belongs to the lowest-numbered class that has at least one member.
- R4: Within that class the victim is the first member found by scanning frame indices upward from the start index and wrapping from the last frame to frame 0.
- R5: The start index is the low log2(NUM_FRAMES) bits of a 16-bit register. The register is seeded with 0xACE1 at reset and shifts left once per victim request. The bit shifted in is the XOR of bits 15, 13, 12 and 10. A request uses the register value held before its own shift.
- R6: `vic_dirty` equals the modified flag that the chosen frame had in the request cycle.
- R7: A cycle with `clr_tick` high clears every referenced flag and leaves every modified flag unchanged.
- R8: When `clr_tick` and an access arrive in the same cycle, the accessed frame keeps its referenced flag set.
- R9: A cycle with `fill_vld` high sets the referenced flag of frame `fill_idx` and clears its modified flag. This takes precedence over an access to the same frame in the same cycle.
- R10: `vic_vld` is high for exactly one cycle, the cycle after each cycle with `vic_req` high. `vic_idx` and `vic_dirty` are computed from the flags as they stood in the request cycle, before that cycle's updates take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access strobe for one frame |
| acc_idx | input | IDX_W | Frame index of the access |
| acc_wr | input | 1 | Access is a write |
| clr_tick | input | 1 | Periodic aging tick: clear all referenced flags |
| fill_vld | input | 1 | Frame has been refilled with a new page |
| fill_idx | input | IDX_W | Frame index of the refill |
| vic_req | input | 1 | Request a victim frame |
| vic_vld | output | 1 | Victim result valid, one cycle after the request |
| vic_idx | output | IDX_W | Chosen victim frame |
| vic_dirty | output | 1 | Victim must be written back before reuse |

## Verification
The hardest situation to reach from the ports is a cycle where two updates land on one frame, and where the order between them only shows up in a later victim choice. This covers a tick together with an access, and a refill together with a write to the same frame. Directed sequences build a frame table in which every other frame sits in a class that lets exactly one competing class win. The outcome of the collision then decides the victim. Constrained random traffic then mixes accesses, ticks, refills and requests. A bench model of the flags and of the shift register predicts every victim index and dirty flag.

// File: rtl/nru_pkg.sv
package nru_pkg;

    typedef enum logic [1:0] {
        CLS_COLD_CLEAN = 2'd0,
        CLS_COLD_DIRTY = 2'd1,
        CLS_HOT_CLEAN  = 2'd2,
        CLS_HOT_DIRTY  = 2'd3
    } nru_cls_e;

    localparam int unsigned NUM_CLASSES = 4;
    localparam int unsigned RNG_W       = 16;
    localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic nru_cls_e cls_of(input logic hot, input logic dirty);
        return nru_cls_e'({hot, dirty});
    endfunction

endpackage

// File: rtl/nru_rng.sv
module nru_rng
    import nru_pkg::*;
#(
    parameter int unsigned OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] start_idx
);

    typedef struct packed {
        logic [RNG_W-1:0] word;
    } rng_state_t;

    rng_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.word = rng_step(st_q.word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= RNG_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_idx = st_q.word[OUT_W-1:0];

endmodule

// File: rtl/nru_class_sort.sv
module nru_class_sort
    import nru_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 16
) (
    input  logic [NUM_FRAMES-1:0] hot_bits,
    input  logic [NUM_FRAMES-1:0] dirty_bits,
    output logic [NUM_FRAMES-1:0] pick_mask
);

    logic [NUM_CLASSES-1:0][NUM_FRAMES-1:0] cls_mask;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        nru_cls_e frame_cls;
        assign frame_cls = cls_of(hot_bits[g], dirty_bits[g]);
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
            assign cls_mask[c][g] = (frame_cls == nru_cls_e'(c));
        end
    end

    always_comb begin
        pick_mask = cls_mask[NUM_CLASSES-1];
        for (int c = NUM_CLASSES - 2; c >= 0; c--) begin
            if (|cls_mask[c]) begin
                pick_mask = cls_mask[c];
            end
        end
    end

endmodule

// File: rtl/nru_rot_pick.sv
module nru_rot_pick #(
    parameter int unsigned NUM_FRAMES = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic [NUM_FRAMES-1:0] cand_mask,
    input  logic [IDX_W-1:0]      start_idx,
    output logic [IDX_W-1:0]      pick_idx
);

    logic [NUM_FRAMES-1:0] rot_mask;

    always_comb begin
        for (int k = 0; k < NUM_FRAMES; k++) begin
            rot_mask[k] = cand_mask[(int'(start_idx) + k) % NUM_FRAMES];
        end
    end

    always_comb begin
        pick_idx = start_idx;
        for (int k = NUM_FRAMES - 1; k >= 0; k--) begin
            if (rot_mask[k]) begin
                pick_idx = IDX_W'((int'(start_idx) + k) % NUM_FRAMES);
            end
        end
    end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
    import nru_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 16,
    parameter int unsigned IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_vld,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_wr,
    input  logic             clr_tick,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             vic_req,
    output logic             vic_vld,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_dirty
);

    typedef struct packed {
        logic [NUM_FRAMES-1:0] hot;
        logic [NUM_FRAMES-1:0] dirty;
        logic                  out_vld;
        logic [IDX_W-1:0]      out_idx;
        logic                  out_dirty;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [IDX_W-1:0]      start_idx;
    logic [NUM_FRAMES-1:0] cand_mask;
    logic [IDX_W-1:0]      pick_idx;
    logic [NUM_FRAMES-1:0] hot_bits;
    logic [NUM_FRAMES-1:0] dirty_bits;

    assign hot_bits   = st_q.hot;
    assign dirty_bits = st_q.dirty;

    nru_rng #(
        .OUT_W (IDX_W)
    ) u_rng (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (vic_req),
        .start_idx (start_idx)
    );

    nru_class_sort #(
        .NUM_FRAMES (NUM_FRAMES)
    ) u_sort (
        .hot_bits   (hot_bits),
        .dirty_bits (dirty_bits),
        .pick_mask  (cand_mask)
    );

    nru_rot_pick #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_pick (
        .cand_mask (cand_mask),
        .start_idx (start_idx),
        .pick_idx  (pick_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = vic_req;
        if (vic_req) begin
            st_d.out_idx   = pick_idx;
            st_d.out_dirty = st_q.dirty[pick_idx];
        end
        // aging first, so a same-cycle access or refill overrides it
        if (clr_tick) begin
            st_d.hot = '0;
        end
        if (acc_vld) begin
            st_d.hot[acc_idx] = 1'b1;
            if (acc_wr) begin
                st_d.dirty[acc_idx] = 1'b1;
            end
        end
        // a refill installs a clean page and wins over any access
        if (fill_vld) begin
            st_d.hot[fill_idx]   = 1'b1;
            st_d.dirty[fill_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vic_vld   = st_q.out_vld;
    assign vic_idx   = st_q.out_idx;
    assign vic_dirty = st_q.out_dirty;

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
    parameter int unsigned NUM_FRAMES = 16,
    parameter int unsigned IDX_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_vld,
    input logic [IDX_W-1:0]      acc_idx,
    input logic                  acc_wr,
    input logic                  clr_tick,
    input logic                  fill_vld,
    input logic [IDX_W-1:0]      fill_idx,
    input logic                  vic_req,
    input logic                  vic_vld,
    input logic [IDX_W-1:0]      vic_idx,
    input logic                  vic_dirty,
    input logic [NUM_FRAMES-1:0] hot_bits,
    input logic [NUM_FRAMES-1:0] dirty_bits
);

    logic [NUM_FRAMES-1:0] prev_hot, prev_dirty;
    logic [1:0]            vic_cls;
    logic                  lower_found;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_hot   <= '0;
            prev_dirty <= '0;
        end else begin
            prev_hot   <= hot_bits;
            prev_dirty <= dirty_bits;
        end
    end

    always_comb begin
        vic_cls     = {prev_hot[vic_idx], prev_dirty[vic_idx]};
        lower_found = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if ({prev_hot[i], prev_dirty[i]} < vic_cls) begin
                lower_found = 1'b1;
            end
        end
    end

    AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_vld); // R10
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_vld); // R10
    AST_LOWEST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld |-> !lower_found); // R3
    AST_DIRTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld |-> (vic_dirty == prev_dirty[vic_idx])); // R6
    AST_ACCESS_SETS_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> hot_bits[$past(acc_idx)]); // R8
    AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr && !(fill_vld && fill_idx == acc_idx)) |=> dirty_bits[$past(acc_idx)]); // R2
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> (hot_bits[$past(fill_idx)] && !dirty_bits[$past(fill_idx)])); // R9
    AST_TICK_CLEARS_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tick && !acc_vld && !fill_vld) |=> (hot_bits == '0)); // R7
    AST_TICK_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tick && !acc_vld && !fill_vld) |=> (dirty_bits == $past(dirty_bits))); // R7

endmodule

bind nru_victim_sel nru_victim_sel_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (acc_vld),
    .acc_idx    (acc_idx),
    .acc_wr     (acc_wr),
    .clr_tick   (clr_tick),
    .fill_vld   (fill_vld),
    .fill_idx   (fill_idx),
    .vic_req    (vic_req),
    .vic_vld    (vic_vld),
    .vic_idx    (vic_idx),
    .vic_dirty  (vic_dirty),
    .hot_bits   (hot_bits),
    .dirty_bits (dirty_bits)
);

// File: tb/nru_victim_sel_tb.sv
`timescale 1ns/1ps
module nru_victim_sel_tb;

    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_vld = 1'b0, acc_wr = 1'b0, clr_tick = 1'b0;
    logic          fill_vld = 1'b0, vic_req = 1'b0;
    logic [IW-1:0] acc_idx = '0, fill_idx = '0;
    logic          vic_vld, vic_dirty;
    logic [IW-1:0] vic_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_hot, m_dirty;
    logic [15:0]  m_rng;

    always #2 clk = ~clk;

    nru_victim_sel #(.NUM_FRAMES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_idx(acc_idx),
        .acc_wr(acc_wr), .clr_tick(clr_tick), .fill_vld(fill_vld),
        .fill_idx(fill_idx), .vic_req(vic_req), .vic_vld(vic_vld),
        .vic_idx(vic_idx), .vic_dirty(vic_dirty)
    );

    function automatic logic [15:0] model_step(input logic [15:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[14:0], fb};
    endfunction

    function automatic logic [IW-1:0] model_pick(input logic [N-1:0] h,
                                                 input logic [N-1:0] d,
                                                 input logic [IW-1:0] st);
        for (int cls = 0; cls < 4; cls++) begin
            for (int k = 0; k < N; k++) begin
                int p;
                p = (int'(st) + k) % N;
                if (int'({h[p], d[p]}) == cls) return IW'(p);
            end
        end
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit a, input bit w, input int ai, input bit c,
                       input bit f, input int fi, input bit r, input string req);
        logic [IW-1:0] e_idx;
        logic          e_dirty;
        e_idx = '0;
        e_dirty = 1'b0;
        acc_vld = a; acc_wr = w; acc_idx = IW'(ai);
        clr_tick = c; fill_vld = f; fill_idx = IW'(fi); vic_req = r;
        if (r) begin
            e_idx   = model_pick(m_hot, m_dirty, m_rng[IW-1:0]);
            e_dirty = m_dirty[e_idx];
            m_rng   = model_step(m_rng);
        end
        if (c) m_hot = '0;
        if (a) begin
            m_hot[ai] = 1'b1;
            if (w) m_dirty[ai] = 1'b1;
        end
        if (f) begin
            m_hot[fi]   = 1'b1;
            m_dirty[fi] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        acc_vld = 0; acc_wr = 0; clr_tick = 0; fill_vld = 0; vic_req = 0;
        check(vic_vld === r, {"R10 ", req}, int'(vic_vld), int'(r));
        if (r) begin
            check(vic_idx === e_idx, {"R3 R4 ", req}, int'(vic_idx), int'(e_idx));
            check(vic_dirty === e_dirty, {"R6 ", req}, int'(vic_dirty), int'(e_dirty));
        end
    endtask

    task automatic do_acc(input int i, input bit w);
        cyc(1, w, i, 0, 0, 0, 0, "access");
    endtask

    task automatic do_req(input string req);
        cyc(0, 0, 0, 0, 0, 0, 1, req);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        m_hot = '0; m_dirty = '0; m_rng = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, first victim is frame 1 and clean
        check(vic_vld === 1'b0, "R1 reset vld", int'(vic_vld), 0);
        do_req("R1 first request");
        // R5 and R4: successive requests rotate the start index
        for (int i = 0; i < 4; i++) do_req("R5 rotation");
        // R2: read every frame but 5, then 5 is the only cold frame
        for (int i = 0; i < N; i++) if (i != 5) do_acc(i, 0);
        do_req("R2 lone cold frame");
        do_acc(5, 1);
        do_req("R2 write marks dirty");
        // R7: tick clears hot flags but keeps dirty ones
        do_acc(3, 1);
        do_acc(9, 1);
        cyc(0, 0, 0, 1, 0, 0, 0, "tick");
        do_req("R7 after tick");
        for (int i = 0; i < N; i++) if (i != 3 && i != 5 && i != 9) do_acc(i, 0);
        do_req("R7 dirty flags survive tick");
        // R8: tick and access to frame 7 in one cycle
        for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, 1, i, 0, "fill");
        for (int i = 0; i < N; i++) if (i != 7) do_acc(i, 1);
        cyc(1, 0, 7, 1, 0, 0, 0, "tick+access");
        do_req("R8 access wins over tick");
        // R9: refill and write to frame 11 in one cycle
        for (int i = 0; i < N; i++) do_acc(i, 1);
        cyc(1, 1, 11, 0, 1, 11, 0, "fill+write");
        do_req("R9 refill wins over write");
        // R6: every frame hot and dirty
        do_acc(11, 1);
        for (int i = 0; i < 3; i++) do_req("R6 all dirty");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit a, w, c, f, r;
            int ai, fi;
            a  = ($urandom % 3) != 0;
            w  = ($urandom % 3) == 0;
            ai = int'($urandom % N);
            c  = ($urandom % 16) == 0;
            f  = ($urandom % 8) == 0;
            fi = int'($urandom % N);
            r  = ($urandom % 3) == 0;
            cyc(a, w, ai, c, f, fi, r, "random R3 R4 R7 R9");
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule